// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block drives the transmit-enable line of a half-duplex RS-485 transceiver from the status of a UART transmitter, and it decides when the transmitter raises its empty interrupt. A single mode bit selects between two behaviours. With the bit clear, the direction pin simply reflects a software or flow-control value, and the interrupt is raised as soon as the holding register empties, even while the shift register is still sending. With the bit set, the pin is driven active as soon as a byte enters the transmit FIFO and is released one full bit time after the final stop bit of the last queued character. The interrupt is then held back until the shift register has drained as well.

The bit time is measured in baud ticks supplied by the UART's baud generator, so the release delay follows the selected oversampling rate. The shifter, baud generator and FIFO stay outside the block. The block only observes their strobes and flags.

Top module: `txdir_ctrl`

## Requirements
- R1: After reset `dir_n` is 1 and `tx_irq` is 0.
- R2: With `auto_en`=1, a `stop_done` pulse seen while `thr_empty`=1 starts a hold-off of N baud ticks, where N is 16 for `osr_sel`=00, 8 for 01 and 4 for 1x, and `osr_sel` is sampled in the `stop_done` cycle. `dir_n` goes from 1 to 0 on the clock edge that samples the Nth tick, counting only ticks in later cycles.
- R3: With `auto_en`=1, a `stop_done` pulse seen while `thr_empty`=0 starts no hold-off, and `dir_n` stays 1 whatever ticks follow.
- R4: With `auto_en`=1, a cycle with `fifo_wr`=1 makes `dir_n` 1 on the next clock edge, including from the released state.
- R5: A `fifo_wr` during the hold-off cancels the pending release, and `dir_n` stays 1 after the remaining ticks arrive.
- R6: With `auto_en`=1, `tx_irq` is set one edge after `thr_empty` and `tsr_empty` become 1 together. `thr_empty` rising alone while `tsr_empty`=0 does not set it.
- R7: With `auto_en`=0, `tx_irq` is set one edge after `thr_empty` rises, whatever the value of `tsr_empty`.
- R8: With `auto_en`=0, `dir_n` equals `sw_rts_n` from the previous cycle, and `stop_done` and `baud_tick` have no effect on it.
- R9: Once set, `tx_irq` stays 1 until a cycle with `fifo_wr` or `irq_ack`, which clears it on the next edge. A clear wins over a set in the same cycle.
- R10: Dropping `auto_en` during a hold-off abandons it. After re-enabling, `dir_n` stays 1 through any number of ticks until a new qualifying `stop_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_en | input | 1 | 1 selects automatic direction control, 0 selects standard mode |
| osr_sel | input | 2 | Oversampling select: 00 gives 16, 01 gives 8, 1x gives 4 ticks per bit |
| fifo_wr | input | 1 | One-cycle strobe for a byte written into the transmit FIFO |
| thr_empty | input | 1 | Transmit holding register (FIFO) empty level |
| tsr_empty | input | 1 | Transmit shift register empty level |
| stop_done | input | 1 | One-cycle pulse at the end of a character's stop bit |
| baud_tick | input | 1 | Oversampling tick from the baud generator |
| sw_rts_n | input | 1 | Software or flow-control pin value used in standard mode |
| irq_ack | input | 1 | Explicit interrupt acknowledge strobe |
| dir_n | output | 1 | Active-low direction pin, registered |
| tx_irq | output | 1 | Transmit-empty interrupt request, registered |

## Verification
The bench builds the block with its default rates of 16, 8 and 4 ticks per bit. Because all three are short, every `osr_sel` value can be run to release, and the window edges can be checked at tick N-1 and tick N. The small counts also leave room to test a FIFO write on the last tick of a hold-off, a mode drop in mid-count, and an interrupt set and clear falling in the same cycle. A behavioural model run beside the design compares both outputs on every cycle.

// File: rtl/txdir_pkg.sv
// Shared types for the line direction controller.
// Assumes: nothing beyond IEEE 1800-2017.
package txdir_pkg;

    // Direction state: driving the line, counting off the last bit, released
    typedef enum logic [1:0] {
        DIR_DRIVE   = 2'd0,
        DIR_HOLD    = 2'd1,
        DIR_RELEASE = 2'd2
    } dir_state_e;

    // Encoding of the oversampling select
    typedef enum logic [1:0] {
        OSR_SEL_HI  = 2'b00,
        OSR_SEL_MID = 2'b01,
        OSR_SEL_LO  = 2'b10
    } osr_code_e;

endpackage

// File: rtl/txdir_bittimer.sv
// One-bit hold-off timer.
// Loads the number of baud ticks in one bit time, chosen by osr_sel, and
// counts down once per baud tick. It flags expiry in the cycle whose tick
// ends the count.
// Assumes: load and abort are single-cycle controls from the direction FSM;
// abort has priority over load.
module txdir_bittimer #(
    parameter int OSR_HI  = 16,
    parameter int OSR_MID = 8,
    parameter int OSR_LO  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       abort,
    input  logic [1:0] osr_sel,
    input  logic       baud_tick,
    output logic       expire
);
    localparam int CNT_W = $clog2(OSR_HI + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // Pick the tick count of one bit from the oversampling select
    always_comb begin
        if (osr_sel[1])
            reload = CNT_W'(OSR_LO);
        else if (osr_sel[0])
            reload = CNT_W'(OSR_MID);
        else
            reload = CNT_W'(OSR_HI);
    end

    // Down-counter: cleared on abort, loaded on start, decremented on ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (abort)
            cnt_q <= '0;
        else if (load)
            cnt_q <= reload;
        else if (baud_tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry: the tick that takes the count from one to zero
    assign expire = baud_tick && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/txdir_pinfsm.sv
// Direction pin state machine.
// In automatic mode it drives the line on every FIFO write. It starts a
// one-bit hold-off when the final stop bit ends with nothing queued, and it
// releases the line when the timer expires. In standard mode the pin
// mirrors sw_rts_n and the machine parks in the driving state.
// Assumes: stop_done and fifo_wr are single-cycle pulses.
module txdir_pinfsm
    import txdir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic fifo_wr,
    input  logic stop_done,
    input  logic thr_empty,
    input  logic expire,
    input  logic sw_rts_n,
    output logic start_hold,
    output logic abort_hold,
    output logic dir_n
);
    dir_state_e state_q, state_d;

    // Abort the timer whenever the hold-off may not continue
    assign abort_hold = !auto_en || fifo_wr;
    // Start the hold-off on the last character's stop bit
    assign start_hold = auto_en && !fifo_wr && (state_q == DIR_DRIVE)
                        && stop_done && thr_empty;

    // Next-state logic: FIFO writes and a mode drop take priority
    always_comb begin
        state_d = state_q;
        if (abort_hold) begin
            state_d = DIR_DRIVE;
        end else begin
            unique case (state_q)
                DIR_DRIVE:   if (start_hold) state_d = DIR_HOLD;
                DIR_HOLD:    if (expire)     state_d = DIR_RELEASE;
                DIR_RELEASE: state_d = DIR_RELEASE;
                default:     state_d = DIR_DRIVE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DIR_DRIVE;
        else
            state_q <= state_d;
    end

    // Registered pin: automatic state or the software value
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_n <= 1'b1;
        else if (auto_en)
            dir_n <= (state_d != DIR_RELEASE);
        else
            dir_n <= sw_rts_n;
    end

endmodule

// File: rtl/txdir_irqgen.sv
// Transmit-empty interrupt generator.
// Watches the empty condition for the current mode: the holding register
// alone in standard mode, the holding and shift registers together in
// automatic mode. It sets a sticky request on that condition's rising edge.
// A FIFO write or an acknowledge clears the request, and a clear wins over
// a set in the same cycle.
// Assumes: the previous condition resets high, so no request appears after
// reset until the transmitter has been busy.
module txdir_irqgen (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic thr_empty,
    input  logic tsr_empty,
    input  logic fifo_wr,
    input  logic irq_ack,
    output logic tx_irq
);
    logic cond;
    logic cond_q;
    logic set_evt;
    logic clr_evt;

    // Empty condition for the mode in force
    assign cond    = auto_en ? (thr_empty && tsr_empty) : thr_empty;
    assign set_evt = cond && !cond_q;
    assign clr_evt = fifo_wr || irq_ack;

    // Edge-detect register for the empty condition
    always_ff @(posedge clk) begin
        if (!rst_n)
            cond_q <= 1'b1;
        else
            cond_q <= cond;
    end

    // Sticky request: clear has priority over set
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_irq <= 1'b0;
        else if (clr_evt)
            tx_irq <= 1'b0;
        else if (set_evt)
            tx_irq <= 1'b1;
    end

endmodule

// File: rtl/txdir_ctrl.sv
// Half-duplex line direction controller, top level.
// Ties together the one-bit timer, the direction state machine and the
// interrupt generator.
// Assumes: every input is synchronous to clk; the UART shifter, baud
// generator and FIFO are external.
module txdir_ctrl #(
    parameter int OSR_HI  = 16,
    parameter int OSR_MID = 8,
    parameter int OSR_LO  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic [1:0] osr_sel,
    input  logic       fifo_wr,
    input  logic       thr_empty,
    input  logic       tsr_empty,
    input  logic       stop_done,
    input  logic       baud_tick,
    input  logic       sw_rts_n,
    input  logic       irq_ack,
    output logic       dir_n,
    output logic       tx_irq
);
    logic start_hold;
    logic abort_hold;
    logic expire;

    txdir_bittimer #(
        .OSR_HI (OSR_HI),
        .OSR_MID(OSR_MID),
        .OSR_LO (OSR_LO)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_hold),
        .abort    (abort_hold),
        .osr_sel  (osr_sel),
        .baud_tick(baud_tick),
        .expire   (expire)
    );

    txdir_pinfsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .fifo_wr   (fifo_wr),
        .stop_done (stop_done),
        .thr_empty (thr_empty),
        .expire    (expire),
        .sw_rts_n  (sw_rts_n),
        .start_hold(start_hold),
        .abort_hold(abort_hold),
        .dir_n     (dir_n)
    );

    txdir_irqgen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_en),
        .thr_empty(thr_empty),
        .tsr_empty(tsr_empty),
        .fifo_wr  (fifo_wr),
        .irq_ack  (irq_ack),
        .tx_irq   (tx_irq)
    );

endmodule

// File: rtl/txdir_ctrl_chk.sv
// Property checker for txdir_ctrl, attached through bind.
module txdir_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       auto_en,
    input logic       fifo_wr,
    input logic       tsr_empty,
    input logic       baud_tick,
    input logic       sw_rts_n,
    input logic       irq_ack,
    input logic       dir_n,
    input logic       tx_irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_n && !tx_irq));

    // R2
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dir_n) && $past(auto_en)) |-> $past(baud_tick));

    // R4
    drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && fifo_wr) |=> dir_n);

    // R6
    irq_waits_shifter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !tsr_empty && !tx_irq) |=> !tx_irq);

    // R8
    pin_follows_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (dir_n == $past(sw_rts_n)));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !fifo_wr && !irq_ack) |=> tx_irq);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr || irq_ack) |=> !tx_irq);

endmodule

bind txdir_ctrl txdir_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .auto_en  (auto_en),
    .fifo_wr  (fifo_wr),
    .tsr_empty(tsr_empty),
    .baud_tick(baud_tick),
    .sw_rts_n (sw_rts_n),
    .irq_ack  (irq_ack),
    .dir_n    (dir_n),
    .tx_irq   (tx_irq)
);

// File: tb/sim_txdir_ctrl.sv
module sim_txdir_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_en = 1'b0;
    logic [1:0] osr_sel = 2'b00;
    logic       fifo_wr = 1'b0;
    logic       thr_empty = 1'b1;
    logic       tsr_empty = 1'b1;
    logic       stop_done = 1'b0;
    logic       baud_tick = 1'b0;
    logic       sw_rts_n = 1'b1;
    logic       irq_ack = 1'b0;
    logic       dir_n;
    logic       tx_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    txdir_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .osr_sel(osr_sel),
        .fifo_wr(fifo_wr), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
        .stop_done(stop_done), .baud_tick(baud_tick), .sw_rts_n(sw_rts_n),
        .irq_ack(irq_ack), .dir_n(dir_n), .tx_irq(tx_irq)
    );

    // Behavioural reference: mode 0 driving, 1 counting, 2 released
    int m_mode = 0;
    int m_left = 0;
    bit m_dir = 1'b1;
    bit m_irq = 1'b0;
    bit m_prev = 1'b1;

    function automatic int bit_ticks(input logic [1:0] s);
        if (s[1]) return 4;
        if (s[0]) return 8;
        return 16;
    endfunction

    always @(posedge clk) begin
        bit empty_now;
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_dir = 1'b1; m_irq = 1'b0; m_prev = 1'b1;
        end else begin
            empty_now = auto_en ? (thr_empty & tsr_empty) : thr_empty;
            if (fifo_wr || irq_ack) m_irq = 1'b0;
            else if (empty_now && !m_prev) m_irq = 1'b1;
            m_prev = empty_now;
            if (!auto_en || fifo_wr) begin
                m_mode = 0;
            end else if (m_mode == 0) begin
                if (stop_done && thr_empty) begin
                    m_mode = 1; m_left = bit_ticks(osr_sel);
                end
            end else if (m_mode == 1 && baud_tick) begin
                m_left = m_left - 1;
                if (m_left == 0) m_mode = 2;
            end
            m_dir = auto_en ? (m_mode != 2) : sw_rts_n;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("model dir_n R2,R8", dir_n, m_dir);
            check("model tx_irq R6,R7", tx_irq, m_irq);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1; cyc(1);
            baud_tick = 1'b0; cyc(1);
        end
    endtask

    task automatic pulse_wr;
        fifo_wr = 1'b1; thr_empty = 1'b0; tsr_empty = 1'b0; cyc(1);
        fifo_wr = 1'b0; cyc(1);
    endtask

    task automatic last_stop;
        thr_empty = 1'b1; tsr_empty = 1'b1; stop_done = 1'b1; cyc(1);
        stop_done = 1'b0;
    endtask

    task automatic finish_run;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        check("R1 dir_n", dir_n, 1'b1);
        check("R1 tx_irq", tx_irq, 1'b0);

        // Standard mode: pin follows software value
        sw_rts_n = 1'b0; cyc(1);
        check("R8 pin low", dir_n, 1'b0);
        stop_done = 1'b1; baud_tick = 1'b1; cyc(1);
        stop_done = 1'b0; baud_tick = 1'b0; ticks(20);
        check("R8 ignores stop/ticks", dir_n, 1'b0);
        sw_rts_n = 1'b1; cyc(1);
        check("R8 pin high", dir_n, 1'b1);

        // Standard mode interrupt on holding register empty
        thr_empty = 1'b0; tsr_empty = 1'b0; cyc(1);
        thr_empty = 1'b1; cyc(1);
        check("R7 irq with shifter busy", tx_irq, 1'b1);
        cyc(5);
        check("R9 irq sticky", tx_irq, 1'b1);
        irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
        check("R9 ack clears", tx_irq, 1'b0);

        // Automatic mode
        auto_en = 1'b1;
        pulse_wr();
        check("R4 driven after write", dir_n, 1'b1);
        thr_empty = 1'b1; cyc(1);
        check("R6 no irq while shifting", tx_irq, 1'b0);
        thr_empty = 1'b0; stop_done = 1'b1; cyc(1); stop_done = 1'b0;
        ticks(20);
        check("R3 more queued keeps line", dir_n, 1'b1);

        // Release delay for each oversampling rate
        for (int k = 0; k < 3; k++) begin
            osr_sel = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b10;
            pulse_wr();
            last_stop();
            check("R6 irq on drain", tx_irq, 1'b1);
            ticks(bit_ticks(osr_sel) - 1);
            check("R2 still driven at N-1", dir_n, 1'b1);
            ticks(1);
            check("R2 released at N", dir_n, 1'b0);
            osr_sel = 2'b00;
            ticks(2);
            check("R2 stays released", dir_n, 1'b0);
        end
        pulse_wr();
        check("R4 write re-drives", dir_n, 1'b1);
        check("R9 write clears irq", tx_irq, 1'b0);

        // Write on the last tick cancels release
        osr_sel = 2'b10;
        last_stop();
        ticks(3);
        baud_tick = 1'b1; fifo_wr = 1'b1; thr_empty = 1'b0; tsr_empty = 1'b0;
        cyc(1);
        baud_tick = 1'b0; fifo_wr = 1'b0;
        ticks(10);
        check("R5 cancel holds line", dir_n, 1'b1);

        // Mode drop mid-count abandons hold-off
        last_stop();
        ticks(2);
        auto_en = 1'b0; cyc(1);
        auto_en = 1'b1; cyc(1);
        ticks(10);
        check("R10 hold abandoned", dir_n, 1'b1);

        // Clear wins over set in the same cycle
        pulse_wr();
        irq_ack = 1'b1; thr_empty = 1'b1; tsr_empty = 1'b1; cyc(1);
        irq_ack = 1'b0;
        check("R9 clear beats set", tx_irq, 1'b0);
        cyc(3);
        check("R9 no late set", tx_irq, 1'b0);

        finish_run();
    end
endmodule